// File: doc/BRIEF.md
# Single-Descriptor DMA Fetch Engine

This block moves one byte buffer between memory and a byte-stream port under the control of a four-word buffer descriptor in memory. Software writes the descriptor base address once. For each job it then supplies a start pulse, a direction bit and a byte count. The engine reads the descriptor in two 8-byte beats: status and sizes come first, then buffer pointer 0 and buffer pointer 1. It checks that hardware owns the descriptor and that it describes a complete single-buffer job. It then streams the buffer out of memory (program direction) or collects stream bytes into memory (read direction).

When the data has moved, the engine writes the status word back with the ownership flag cleared. It touches only the low four bytes of that beat. In the following cycle it pulses the completion event for the direction. A descriptor that fails the check produces a descriptor-unavailable pulse, and no data or memory write follows. The memory side is a single-outstanding request/acknowledge port, 8 bytes wide, with byte strobes. Addresses are issued as supplied. Descriptors and buffers are expected to be 8-byte aligned.

Top module: `bd_fetch_dma`

## Requirements
- R1: After reset the engine is idle: `busy`, `mem_req`, `tx_valid`, `rx_ready` and all three event outputs are low.
- R2: A job reads the descriptor with two read beats, at the base address and at base+8. The first beat holds the status word in bytes 0-3 and the sizes word in bytes 4-7. The second holds buffer pointer 0 in bytes 0-3 and buffer pointer 1 in bytes 4-7. A request holds its address and direction until acknowledged.
- R3: A descriptor is accepted only if status bit 31 (hardware owned), bit 3 (first) and bit 2 (last) are all set. Otherwise the engine pulses `evt_unavail`, moves no stream byte, writes no memory, leaves the status word unchanged and returns to idle.
- R4: With `dir`=0 (program), the engine reads 8-byte beats starting at pointer 0. It presents their bytes on `tx_data` in ascending byte-lane order (lane 0 = bits 7:0). It stops after exactly the job length in bytes.
- R5: With `dir`=1 (read), the engine accepts exactly the job length in bytes from the rx port. It packs them into ascending lanes and writes full 8-byte beats (strobe 0xFF) starting at pointer 0. Lanes past the last valid byte in the final beat are written as zero, and memory beyond that beat is not written.
- R6: The job length is the smaller of `cmd_count` and the descriptor size field rounded up to a multiple of 8. The size field is the low 12 bits of the sizes word. Buffer pointer 1 and the upper bits of the sizes word have no effect.
- R7: After the data phase the status word is written back with bit 31 cleared and every other bit kept, using strobe 0x0F at the descriptor base. The completion event rises in the cycle after that write is acknowledged.
- R8: `evt_tx_done` (program) and `evt_rx_done` (read) and `evt_unavail` are single-cycle pulses. At most one fires per job and never two at once.
- R9: `busy` is high from the cycle after an accepted start until the job's event. A start pulse while busy is ignored.
- R10: A job length of zero moves no data and issues no buffer beat. It still writes the status back and signals completion.
- R11: While `tx_valid` is high and `tx_ready` low, `tx_valid` and `tx_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| base_we | input | 1 | Load descriptor base address |
| base_wdata | input | ADDR_W | Descriptor base address value |
| start | input | 1 | Launch a job (ignored while busy) |
| dir | input | 1 | 0 = memory to stream, 1 = stream to memory |
| cmd_count | input | LEN_W | Unrounded job byte count |
| busy | output | 1 | Job in progress |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Request byte address |
| mem_wdata | output | 64 | Write data |
| mem_wstrb | output | 8 | Write byte strobes |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 64 | Read data |
| tx_valid | output | 1 | Outgoing stream byte valid |
| tx_data | output | 8 | Outgoing stream byte |
| tx_ready | input | 1 | Outgoing stream sink ready |
| rx_valid | input | 1 | Incoming stream byte valid |
| rx_data | input | 8 | Incoming stream byte |
| rx_ready | output | 1 | Engine accepts an incoming byte |
| evt_tx_done | output | 1 | Program-direction job complete |
| evt_rx_done | output | 1 | Read-direction job complete |
| evt_unavail | output | 1 | Descriptor not usable |

## Verification
A corrupted byte counter or lane index appears on the ports as a wrong stream byte count, a misordered byte, or nonzero padding in the final memory beat. Each of these is visible within one beat of the fault. A bad state transition shows up as a missing or doubled event pulse. It can also show up as a status write-back that leaves bit 31 set, or a memory write after an unavailable descriptor. These are caught by the end of the job, and the write-back and event-ordering properties catch them on the exact cycle.

// File: rtl/bd_fetch_pkg.sv
package bd_fetch_pkg;

    localparam int BUS_BYTES = 8;
    localparam int DATA_W    = 8 * BUS_BYTES;
    localparam int LANE_W    = $clog2(BUS_BYTES);
    localparam int WORD_W    = 32;

    localparam int OWN_BIT   = 31;
    localparam int FIRST_BIT = 3;
    localparam int LAST_BIT  = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DESC0,
        ST_DESC1,
        ST_TX_RD,
        ST_TX_SEND,
        ST_RX_FILL,
        ST_RX_WR,
        ST_WB
    } st_e;

endpackage

// File: rtl/bd_fetch_desc_check.sv
module bd_fetch_desc_check #(
    parameter int LEN_W = 12,
    parameter int ALIGN = 8
) (
    input  logic             own_flag,
    input  logic             first_flag,
    input  logic             last_flag,
    input  logic [LEN_W-1:0] size_field,
    input  logic [LEN_W-1:0] cmd_count,
    output logic             accept,
    output logic [LEN_W-1:0] limit
);

    localparam logic [LEN_W:0] LOW_MASK = (LEN_W+1)'(ALIGN - 1);

    logic [LEN_W:0] padded;
    logic [LEN_W:0] rounded;

    // Size rounded up to the bus width, one bit wider to hold the carry.
    assign padded  = {1'b0, size_field} + LOW_MASK;
    assign rounded = padded & ~LOW_MASK;

    // Job length is the tighter of command count and rounded size.
    assign limit  = ({1'b0, cmd_count} <= rounded) ? cmd_count : rounded[LEN_W-1:0];
    assign accept = own_flag & first_flag & last_flag;

endmodule

// File: rtl/bd_fetch_byte_lane.sv
module bd_fetch_byte_lane #(
    parameter int BYTES  = 8,
    parameter int LANE_W = 3
) (
    input  logic [8*BYTES-1:0] word_in,
    input  logic [LANE_W-1:0]  lane,
    input  logic [7:0]         byte_in,
    output logic [7:0]         byte_out,
    output logic [8*BYTES-1:0] word_out
);

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        assign word_out[8*g +: 8] = (lane == LANE_W'(g)) ? byte_in : word_in[8*g +: 8];
    end

    always_comb begin
        byte_out = '0;
        for (int k = 0; k < BYTES; k++) begin
            if (lane == LANE_W'(k)) begin
                byte_out = word_in[8*k +: 8];
            end
        end
    end

endmodule

// File: rtl/bd_fetch_dma.sv
module bd_fetch_dma
    import bd_fetch_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 base_we,
    input  logic [ADDR_W-1:0]    base_wdata,
    input  logic                 start,
    input  logic                 dir,
    input  logic [LEN_W-1:0]     cmd_count,
    output logic                 busy,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic [BUS_BYTES-1:0] mem_wstrb,
    input  logic                 mem_ack,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 tx_valid,
    output logic [7:0]           tx_data,
    input  logic                 tx_ready,
    input  logic                 rx_valid,
    input  logic [7:0]           rx_data,
    output logic                 rx_ready,
    output logic                 evt_tx_done,
    output logic                 evt_rx_done,
    output logic                 evt_unavail
);

    localparam logic [ADDR_W-1:0]    BEAT_STEP   = ADDR_W'(BUS_BYTES);
    localparam logic [BUS_BYTES-1:0] STRB_ALL    = '1;
    localparam logic [BUS_BYTES-1:0] STRB_STATUS = BUS_BYTES'((1 << (WORD_W / 8)) - 1);
    localparam logic [LANE_W-1:0]    LANE_LAST   = LANE_W'(BUS_BYTES - 1);
    localparam logic [WORD_W-1:0]    OWN_MASK    = WORD_W'(1) << OWN_BIT;

    typedef struct packed {
        st_e               st;
        logic              dir;
        logic [LEN_W-1:0]  cmd;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] desc;
        logic [ADDR_W-1:0] ptr;
        logic [WORD_W-1:0] status;
        logic [LEN_W-1:0]  limit;
        logic [LEN_W-1:0]  moved;
        logic [LANE_W-1:0] lane;
        logic [DATA_W-1:0] word;
        logic              ev_tx;
        logic              ev_rx;
        logic              ev_un;
    } regs_t;

    regs_t r_q, r_d;

    logic             desc_ok;
    logic [LEN_W-1:0] desc_limit;
    logic [7:0]       lane_byte;
    logic [DATA_W-1:0] word_ins;
    logic [LEN_W-1:0] moved_inc;
    logic             last_byte;

    bd_fetch_desc_check #(
        .LEN_W (LEN_W),
        .ALIGN (BUS_BYTES)
    ) u_desc_check (
        .own_flag   (mem_rdata[OWN_BIT]),
        .first_flag (mem_rdata[FIRST_BIT]),
        .last_flag  (mem_rdata[LAST_BIT]),
        .size_field (mem_rdata[WORD_W +: LEN_W]),
        .cmd_count  (r_q.cmd),
        .accept     (desc_ok),
        .limit      (desc_limit)
    );

    bd_fetch_byte_lane #(
        .BYTES  (BUS_BYTES),
        .LANE_W (LANE_W)
    ) u_byte_lane (
        .word_in  (r_q.word),
        .lane     (r_q.lane),
        .byte_in  (rx_data),
        .byte_out (lane_byte),
        .word_out (word_ins)
    );

    assign moved_inc = r_q.moved + LEN_W'(1);
    assign last_byte = (moved_inc == r_q.limit);

    always_comb begin
        r_d       = r_q;
        r_d.ev_tx = 1'b0;
        r_d.ev_rx = 1'b0;
        r_d.ev_un = 1'b0;

        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_q.desc;
        mem_wdata = '0;
        mem_wstrb = '0;
        tx_valid  = 1'b0;
        rx_ready  = 1'b0;

        if (base_we) begin
            r_d.base = base_wdata;
        end

        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_DESC0;
                    r_d.dir   = dir;
                    r_d.cmd   = cmd_count;
                    r_d.desc  = r_q.base;
                    r_d.moved = '0;
                    r_d.lane  = '0;
                    r_d.word  = '0;
                end
            end

            ST_DESC0: begin
                mem_req  = 1'b1;
                mem_addr = r_q.desc;
                if (mem_ack) begin
                    if (desc_ok) begin
                        r_d.status = mem_rdata[WORD_W-1:0];
                        r_d.limit  = desc_limit;
                        r_d.st     = ST_DESC1;
                    end else begin
                        r_d.ev_un = 1'b1;
                        r_d.st    = ST_IDLE;
                    end
                end
            end

            ST_DESC1: begin
                mem_req  = 1'b1;
                mem_addr = r_q.desc + BEAT_STEP;
                if (mem_ack) begin
                    r_d.ptr = mem_rdata[ADDR_W-1:0];
                    if (r_q.limit == '0) begin
                        r_d.st = ST_WB;
                    end else if (r_q.dir) begin
                        r_d.st = ST_RX_FILL;
                    end else begin
                        r_d.st = ST_TX_RD;
                    end
                end
            end

            ST_TX_RD: begin
                mem_req  = 1'b1;
                mem_addr = r_q.ptr;
                if (mem_ack) begin
                    r_d.word = mem_rdata;
                    r_d.lane = '0;
                    r_d.st   = ST_TX_SEND;
                end
            end

            ST_TX_SEND: begin
                tx_valid = 1'b1;
                if (tx_ready) begin
                    r_d.moved = moved_inc;
                    r_d.lane  = r_q.lane + LANE_W'(1);
                    if (last_byte) begin
                        r_d.st = ST_WB;
                    end else if (r_q.lane == LANE_LAST) begin
                        r_d.ptr = r_q.ptr + BEAT_STEP;
                        r_d.st  = ST_TX_RD;
                    end
                end
            end

            ST_RX_FILL: begin
                rx_ready = 1'b1;
                if (rx_valid) begin
                    r_d.word  = word_ins;
                    r_d.moved = moved_inc;
                    r_d.lane  = r_q.lane + LANE_W'(1);
                    if (last_byte || (r_q.lane == LANE_LAST)) begin
                        r_d.st = ST_RX_WR;
                    end
                end
            end

            ST_RX_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.ptr;
                mem_wdata = r_q.word;
                mem_wstrb = STRB_ALL;
                if (mem_ack) begin
                    r_d.ptr  = r_q.ptr + BEAT_STEP;
                    r_d.word = '0;
                    r_d.lane = '0;
                    r_d.st   = (r_q.moved == r_q.limit) ? ST_WB : ST_RX_FILL;
                end
            end

            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.desc;
                mem_wdata = DATA_W'(r_q.status & ~OWN_MASK);
                mem_wstrb = STRB_STATUS;
                if (mem_ack) begin
                    r_d.ev_tx = ~r_q.dir;
                    r_d.ev_rx = r_q.dir;
                    r_d.st    = ST_IDLE;
                end
            end

            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy        = (r_q.st != ST_IDLE);
    assign tx_data     = lane_byte;
    assign evt_tx_done = r_q.ev_tx;
    assign evt_rx_done = r_q.ev_rx;
    assign evt_unavail = r_q.ev_un;

    // Event outputs never overlap.
    assert_event_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({evt_tx_done, evt_rx_done, evt_unavail}));

    // Completion only follows an acknowledged status write-back.
    assert_done_after_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_tx_done || evt_rx_done) |->
            $past(mem_req && mem_ack && mem_we && (mem_wstrb == STRB_STATUS)));

    // The status write-back always hands ownership back.
    assert_wb_own_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && (mem_wstrb == STRB_STATUS)) |-> !mem_wdata[OWN_BIT]);

    // Unavailable follows a descriptor read and leaves the engine idle.
    assert_unavail_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_unavail |-> (!busy && $past(mem_req && mem_ack && !mem_we)));

    // A pending memory request is held unchanged.
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // Outgoing stream byte is held while the sink stalls.
    assert_tx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // Byte progress never passes the job length.
    assert_moved_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.moved <= r_q.limit));

    // Idle engine drives no traffic.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> (!mem_req && !tx_valid && !rx_ready
                                      && !evt_tx_done && !evt_rx_done));

endmodule

// File: tb/bd_fetch_dma_bench.sv
module bd_fetch_dma_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_we = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        start = 1'b0;
    logic        dir = 1'b0;
    logic [11:0] cmd_count = '0;
    logic        busy;
    logic        mem_req;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [7:0]  mem_wstrb;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        evt_tx_done;
    logic        evt_rx_done;
    logic        evt_unavail;

    always #5ns clk = ~clk;

    bd_fetch_dma u_bd_fetch_dma (
        .clk         (clk),
        .rst_n       (rst_n),
        .base_we     (base_we),
        .base_wdata  (base_wdata),
        .start       (start),
        .dir         (dir),
        .cmd_count   (cmd_count),
        .busy        (busy),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_wstrb   (mem_wstrb),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .tx_valid    (tx_valid),
        .tx_data     (tx_data),
        .tx_ready    (tx_ready),
        .rx_valid    (rx_valid),
        .rx_data     (rx_data),
        .rx_ready    (rx_ready),
        .evt_tx_done (evt_tx_done),
        .evt_rx_done (evt_rx_done),
        .evt_unavail (evt_unavail)
    );

    logic [63:0] mem [0:511];
    logic [7:0]  tx_got [0:4095];
    logic [7:0]  rx_src [0:255];

    int n_chk = 0;
    int n_fail = 0;
    int n_ev_tx = 0;
    int n_ev_rx = 0;
    int n_ev_un = 0;
    int tx_n = 0;
    int rx_idx = 0;
    int mem_lat = 0;
    int wait_cnt = 0;
    bit rx_pend = 1'b0;
    bit tx_stall = 1'b0;
    bit rx_stall = 1'b0;
    bit tphase = 1'b0;
    bit rphase = 1'b0;
    bit done_flag = 1'b0;
    logic [31:0] ev_base = '0;
    logic [31:0] status_at_ev = '0;

    function automatic logic [7:0] rd8(input logic [31:0] a);
        return mem[a[11:3]][8*a[2:0] +: 8];
    endfunction

    function automatic logic [31:0] rd32(input logic [31:0] a);
        return {rd8(a + 3), rd8(a + 2), rd8(a + 1), rd8(a)};
    endfunction

    task automatic wr8(input logic [31:0] a, input logic [7:0] v);
        mem[a[11:3]][8*a[2:0] +: 8] = v;
    endtask

    task automatic wr32(input logic [31:0] a, input logic [31:0] v);
        for (int b = 0; b < 4; b++) wr8(a + b, v[8*b +: 8]);
    endtask

    // Memory model: ack after mem_lat waiting cycles, one cycle wide.
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wait_cnt < mem_lat) begin
                wait_cnt++;
            end else begin
                wait_cnt  = 0;
                mem_ack   = 1'b1;
                mem_rdata = mem[mem_addr[11:3]];
                if (mem_we) begin
                    for (int b = 0; b < 8; b++)
                        if (mem_wstrb[b]) mem[mem_addr[11:3]][8*b +: 8] = mem_wdata[8*b +: 8];
                end
            end
        end
    end

    // Outgoing stream sink.
    always @(negedge clk) begin
        tphase   = ~tphase;
        tx_ready = tx_stall ? tphase : 1'b1;
        #1ns;
        if (tx_valid && tx_ready) begin
            tx_got[tx_n] = tx_data;
            tx_n++;
        end
    end

    // Incoming stream source.
    always @(negedge clk) begin
        if (rx_pend) rx_idx++;
        rphase   = ~rphase;
        rx_valid = rx_stall ? rphase : 1'b1;
        rx_data  = rx_src[rx_idx[7:0]];
        #1ns;
        rx_pend = rx_valid && rx_ready;
    end

    // Event monitor.
    always @(negedge clk) begin
        #2ns;
        if (evt_tx_done) begin n_ev_tx++; status_at_ev = rd32(ev_base); end
        if (evt_rx_done) begin n_ev_rx++; status_at_ev = rd32(ev_base); end
        if (evt_unavail) n_ev_un++;
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic clear_counts();
        tx_n = 0; rx_idx = 0; n_ev_tx = 0; n_ev_rx = 0; n_ev_un = 0;
    endtask

    task automatic set_desc(input logic [31:0] base, input logic [31:0] st,
                            input logic [31:0] sz, input logic [31:0] p0, input logic [31:0] p1);
        wr32(base, st); wr32(base + 4, sz); wr32(base + 8, p0); wr32(base + 12, p1);
        ev_base = base;
        @(negedge clk);
        base_we = 1'b1; base_wdata = base;
        @(negedge clk);
        base_we = 1'b0;
    endtask

    task automatic launch(input logic d, input logic [11:0] cnt);
        clear_counts();
        @(negedge clk);
        dir = d; cmd_count = cnt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_event(input string req);
        int k;
        k = 0;
        while ((n_ev_tx + n_ev_rx + n_ev_un) == 0 && k < 3000) begin
            @(negedge clk);
            #3ns;
            k++;
        end
        check(req, "job ended with an event", 64'((n_ev_tx + n_ev_rx + n_ev_un) != 0), 64'd1);
        repeat (4) @(negedge clk);
        #3ns;
    endtask

    task automatic t_reset();
        #3ns;
        check("R1", "busy", busy, 0);
        check("R1", "mem_req", mem_req, 0);
        check("R1", "tx_valid", tx_valid, 0);
        check("R1", "rx_ready", rx_ready, 0);
        check("R1", "events", {evt_tx_done, evt_rx_done, evt_unavail}, 0);
    endtask

    task automatic t_tx_basic();
        bit ok;
        for (int i = 0; i < 16; i++) wr8(32'h400 + i, 8'(i * 7 + 3));
        for (int i = 0; i < 16; i++) wr8(32'h800 + i, 8'hEE);
        set_desc(32'h100, 32'h8000_003C, 32'h0000_F010, 32'h400, 32'h800);
        launch(1'b0, 12'd13);
        wait_event("R4");
        check("R4", "tx byte count", tx_n, 13);
        ok = 1'b1;
        for (int i = 0; i < 13; i++) if (tx_got[i] !== 8'(i * 7 + 3)) ok = 1'b0;
        check("R4", "tx bytes in lane order from pointer 0", ok, 1);
        check("R8", "tx done pulses", n_ev_tx, 1);
        check("R8", "no other event", n_ev_rx + n_ev_un, 0);
        check("R7", "status written back", rd32(32'h100), 32'h0000_003C);
        check("R7", "status already cleared at event", status_at_ev, 32'h0000_003C);
        check("R6", "sizes word untouched", rd32(32'h104), 32'h0000_F010);
        check("R9", "busy low after job", busy, 0);
    endtask

    task automatic t_tx_stall();
        bit ok;
        for (int i = 0; i < 24; i++) wr8(32'h600 + i, 8'(i) ^ 8'h5A);
        set_desc(32'h180, 32'h8000_000C, 32'd24, 32'h600, 32'h0);
        mem_lat = 2; tx_stall = 1'b1;
        launch(1'b0, 12'd24);
        wait_event("R11");
        mem_lat = 0; tx_stall = 1'b0;
        check("R11", "stalled tx byte count", tx_n, 24);
        ok = 1'b1;
        for (int i = 0; i < 24; i++) if (tx_got[i] !== (8'(i) ^ 8'h5A)) ok = 1'b0;
        check("R11", "stalled tx bytes across three beats", ok, 1);
        check("R2", "desc read via base held under latency", n_ev_tx, 1);
    endtask

    task automatic t_rx_basic();
        bit ok;
        for (int i = 0; i < 32; i++) wr8(32'hA00 + i, 8'hAA);
        for (int i = 0; i < 256; i++) rx_src[i] = 8'(8'h30 + i);
        set_desc(32'h200, 32'h8000_000C, 32'd16, 32'hA00, 32'h0);
        mem_lat = 1; rx_stall = 1'b1;
        launch(1'b1, 12'd11);
        wait_event("R5");
        mem_lat = 0; rx_stall = 1'b0;
        check("R5", "rx bytes consumed", rx_idx, 11);
        ok = 1'b1;
        for (int i = 0; i < 11; i++) if (rd8(32'hA00 + i) !== 8'(8'h30 + i)) ok = 1'b0;
        check("R5", "rx bytes stored in lane order", ok, 1);
        ok = 1'b1;
        for (int i = 11; i < 16; i++) if (rd8(32'hA00 + i) !== 8'h00) ok = 1'b0;
        check("R5", "final-beat padding zero", ok, 1);
        ok = 1'b1;
        for (int i = 16; i < 32; i++) if (rd8(32'hA00 + i) !== 8'hAA) ok = 1'b0;
        check("R5", "memory past last beat untouched", ok, 1);
        check("R8", "rx done pulses", n_ev_rx, 1);
        check("R7", "rx status cleared", rd32(32'h200), 32'h0000_000C);
    endtask

    task automatic t_unowned();
        for (int i = 0; i < 16; i++) wr8(32'hC00 + i, 8'h11);
        set_desc(32'h280, 32'h0000_000C, 32'd16, 32'hC00, 32'h0);
        launch(1'b0, 12'd8);
        wait_event("R3");
        check("R3", "unavailable pulses", n_ev_un, 1);
        check("R3", "no completion", n_ev_tx + n_ev_rx, 0);
        check("R3", "no tx bytes", tx_n, 0);
        check("R3", "status unchanged", rd32(32'h280), 32'h0000_000C);
        check("R3", "idle after", busy, 0);
    endtask

    task automatic t_not_single();
        bit ok;
        set_desc(32'h2C0, 32'h8000_0008, 32'd16, 32'hC00, 32'h0);
        launch(1'b1, 12'd8);
        wait_event("R3");
        check("R3", "last-marker missing gives unavailable", n_ev_un, 1);
        check("R3", "no rx bytes taken", rx_idx, 0);
        ok = 1'b1;
        for (int i = 0; i < 16; i++) if (rd8(32'hC00 + i) !== 8'h11) ok = 1'b0;
        check("R3", "buffer not written", ok, 1);
        check("R3", "owned status left set", rd32(32'h2C0), 32'h8000_0008);
    endtask

    task automatic t_limit();
        for (int i = 0; i < 48; i++) wr8(32'hD00 + i, 8'(i + 1));
        set_desc(32'h300, 32'h8000_000C, 32'd5, 32'hD00, 32'h0);
        launch(1'b0, 12'd20);
        wait_event("R6");
        check("R6", "size 5 rounds to 8 and caps count 20", tx_n, 8);
        check("R6", "last capped byte", tx_got[7], 8'd8);
        set_desc(32'h300, 32'h8000_000C, 32'd40, 32'hD00, 32'h0);
        launch(1'b0, 12'd9);
        wait_event("R6");
        check("R6", "count 9 below size 40", tx_n, 9);
        check("R6", "ninth byte from second beat", tx_got[8], 8'd9);
    endtask

    task automatic t_zero();
        bit ok;
        for (int i = 0; i < 16; i++) wr8(32'hE00 + i, 8'h77);
        set_desc(32'h340, 32'h8000_000C, 32'd16, 32'hE00, 32'h0);
        launch(1'b1, 12'd0);
        wait_event("R10");
        check("R10", "zero-length rx done", n_ev_rx, 1);
        check("R10", "no bytes taken", rx_idx, 0);
        ok = 1'b1;
        for (int i = 0; i < 16; i++) if (rd8(32'hE00 + i) !== 8'h77) ok = 1'b0;
        check("R10", "buffer untouched", ok, 1);
        check("R10", "status still written back", rd32(32'h340), 32'h0000_000C);
    endtask

    task automatic t_busy();
        bit ok;
        for (int i = 0; i < 16; i++) wr8(32'hF00 + i, 8'(8'hC0 + i));
        set_desc(32'h380, 32'h8000_000C, 32'd16, 32'hF00, 32'h0);
        tx_stall = 1'b1;
        launch(1'b0, 12'd16);
        repeat (5) @(negedge clk);
        #3ns;
        check("R9", "busy during job", busy, 1);
        dir = 1'b1; cmd_count = 12'd8; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_event("R9");
        tx_stall = 1'b0;
        repeat (20) @(negedge clk);
        #3ns;
        check("R9", "single tx completion", n_ev_tx, 1);
        check("R9", "ignored start made no rx job", n_ev_rx, 0);
        check("R9", "no rx bytes taken", rx_idx, 0);
        check("R9", "tx length kept", tx_n, 16);
        ok = 1'b1;
        for (int i = 0; i < 16; i++) if (tx_got[i] !== 8'(8'hC0 + i)) ok = 1'b0;
        check("R9", "tx data unaffected", ok, 1);
        check("R9", "idle at end", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < 512; i++) mem[i] = '0;
        for (int i = 0; i < 256; i++) rx_src[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_basic();
        t_tx_stall();
        t_rx_basic();
        t_unowned();
        t_not_single();
        t_limit();
        t_zero();
        t_busy();
        done_flag = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule